// File: doc/BRIEF.md
# Touch-Tone Key Decoder

This block recovers a telephone keypad digit from two square waves. One wave comes from the low (row) band and the other from the high (column) band; both have already been filtered and limited outside the block. Each wave's rising-edge-to-rising-edge period is measured in reference clock cycles and compared with the four nominal periods of its band. A tone counts as present once four consecutive periods fall inside the same window of plus or minus one fortieth of nominal. When a row tone and a column tone are present together, the early steering flag rises. A steering state machine then times how long the pair lasts. If it lasts long enough, the machine loads the 4-bit key code into a latch and, after a short settling interval, raises the delayed steering flag.

The latched code is placed on the key bus only while the output enable is high; a separate drive flag marks when the bus is meaningful. A high inhibit input blocks recognition of the 1633 Hz column, so that the letter keys cannot register and the latch keeps its previous code. All timing is counted in clock cycles: the reference clock rate, the guard time and the settling interval are parameters.

The steering state machine has five states. IDLE goes to QUALIFY when early steering rises. QUALIFY goes back to IDLE if early steering drops; it goes to SETTLE, loading the latch, after GUARD_CYC cycles. SETTLE goes to IDLE if early steering drops; it goes to HOLD after SETTLE_CYC cycles. HOLD goes to RELEASE when early steering falls. RELEASE goes back to HOLD if early steering returns; it goes to IDLE after GUARD_CYC cycles.

Top module: `dtmf_decoder`

## Requirements
- R1: After reset, early steering and delayed steering are low and the latched code is 0000.
- R2: A tone is accepted only when four consecutive periods lie within nominal ±1/40 of one band frequency, where nominal = CLK_HZ / f. The low band is 697, 770, 852 and 941 Hz (row index 0..3). The high band is 1209, 1336, 1477 and 1633 Hz (column index 0..3). A tone 10% off nominal is never accepted.
- R3: A single tone in only one band never raises early steering.
- R4: Early steering is high only while both bands hold a valid tone. It falls once either tone stops, at most one longest period plus a few cycles later.
- R5: If early steering stays high, delayed steering rises exactly GUARD_CYC + SETTLE_CYC + 1 cycles after early steering rises.
- R6: Key codes: digits 1..9 give their binary value, 0 gives 1010, * gives 1011, # gives 1100, and A, B, C, D give 1101, 1110, 1111, 0000. Keys are row-major: row 0 holds 1 2 3 A, row 1 holds 4 5 6 B, row 2 holds 7 8 9 C, row 3 holds * 0 # D.
- R7: Delayed steering falls exactly GUARD_CYC + 1 cycles after early steering falls, provided early steering does not return in that time.
- R8: key_out shows the latched code while out_en is high and is 0000 otherwise. key_drive equals out_en.
- R9: While inhibit is high, the 1633 Hz column is never accepted, so A/B/C/D do not raise early steering and the latched code is kept. The other columns decode normally.
- R10: The latched code changes only while delayed steering is low, and it holds after the tones stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (CLK_HZ) |
| rst_n | input | 1 | Active-low synchronous reset |
| tone_low | input | 1 | Limited low-band square wave |
| tone_high | input | 1 | Limited high-band square wave |
| inhibit | input | 1 | Blocks the 1633 Hz column |
| out_en | input | 1 | Enables the key bus |
| esteer | output | 1 | Early steering: both tones valid |
| dsteer | output | 1 | Delayed steering: key registered |
| key_out | output | 4 | Latched key code, 0 when disabled |
| key_drive | output | 1 | High when key_out is driven |

## Verification
The exact steering latencies are the hardest part to reach from the ports. They only show up after a tone pair has first passed four clean period measurements in both bands, and after both meters have later timed out when the tones stop. The bench drives exact integer-period square waves from its own tone processes and synchronises its cycle counting to the first cycle in which early steering is seen high or low. It then compares the count against the guard and settle parameters. The inhibit case holds the latch with a known code from a previous key and then presents a letter key, so an unwanted update would show on the bus.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QUALIFY,
        ST_SETTLE,
        ST_HOLD,
        ST_RELEASE
    } steer_state_t;

    // Nominal frequency of one band entry; index order is fixed by the key layout.
    function automatic int unsigned group_hz(input bit high, input logic [1:0] idx);
        int unsigned f;
        if (!high) begin
            unique case (idx)
                2'd0: f = 697;
                2'd1: f = 770;
                2'd2: f = 852;
                default: f = 941;
            endcase
        end else begin
            unique case (idx)
                2'd0: f = 1209;
                2'd1: f = 1336;
                2'd2: f = 1477;
                default: f = 1633;
            endcase
        end
        return f;
    endfunction

    // True when a measured period lies within nominal +/- nominal/40.
    function automatic bit in_window(input int unsigned clk_hz, input int unsigned f,
                                     input int unsigned meas);
        int unsigned nom;
        int unsigned tol;
        nom = clk_hz / f;
        tol = nom / 40;
        return (meas >= nom - tol) && (meas <= nom + tol);
    endfunction

endpackage

// File: rtl/dtmf_tone_meter.sv
module dtmf_tone_meter
    import dtmf_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 3579545,
    parameter bit          HIGH_GROUP = 1'b0,
    parameter int unsigned MIN_RUN    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tone_in,
    input  logic       block_top,
    output logic       tone_ok,
    output logic [1:0] tone_sel
);
    localparam int unsigned LONGEST = CLK_HZ / group_hz(HIGH_GROUP, 2'd0);
    localparam int unsigned CNT_MAX = LONGEST + LONGEST / 40 + 2;
    localparam int unsigned CW      = $clog2(CNT_MAX + 1);
    localparam int unsigned RW      = $clog2(MIN_RUN + 1);

    logic [2:0]    sync_q;
    logic          rise;
    logic [CW-1:0] cnt_q;
    logic [RW-1:0] run_q;
    logic [1:0]    sel_q;
    logic          hit;
    logic [1:0]    hit_sel;

    assign rise = sync_q[1] & ~sync_q[2];

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], tone_in};
    end

    // Compare the period just ended against every window of this band.
    always_comb begin
        hit     = 1'b0;
        hit_sel = 2'd0;
        for (int k = 0; k < 4; k++) begin
            if (in_window(CLK_HZ, group_hz(HIGH_GROUP, 2'(k)), 32'(cnt_q))) begin
                hit     = 1'b1;
                hit_sel = 2'(k);
            end
        end
        if (block_top && hit_sel == 2'd3) hit = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CW'(CNT_MAX);
            run_q <= '0;
            sel_q <= 2'd0;
        end else if (rise) begin
            cnt_q <= CW'(1);
            if (hit) begin
                if (run_q != '0 && hit_sel == sel_q) begin
                    if (run_q != RW'(MIN_RUN)) run_q <= run_q + RW'(1);
                end else begin
                    run_q <= RW'(1);
                    sel_q <= hit_sel;
                end
            end else begin
                run_q <= '0;
            end
        end else if (cnt_q != CW'(CNT_MAX)) begin
            cnt_q <= cnt_q + CW'(1);
        end else begin
            run_q <= '0;
        end
    end

    assign tone_ok  = (run_q == RW'(MIN_RUN)) && !(block_top && sel_q == 2'd3);
    assign tone_sel = sel_q;

endmodule

// File: rtl/dtmf_key_map.sv
module dtmf_key_map (
    input  logic [1:0] row,
    input  logic [1:0] col,
    output logic [3:0] code
);
    always_comb begin
        if (col == 2'd3) begin
            code = (row == 2'd3) ? 4'd0 : 4'd13 + {2'b00, row};
        end else if (row == 2'd3) begin
            unique case (col)
                2'd0:    code = 4'd11;
                2'd1:    code = 4'd10;
                default: code = 4'd12;
            endcase
        end else begin
            code = 4'({2'b00, row} * 4'd3) + {2'b00, col} + 4'd1;
        end
    end
endmodule

// File: rtl/dtmf_steer_fsm.sv
module dtmf_steer_fsm
    import dtmf_pkg::*;
#(
    parameter int unsigned GUARD_CYC  = 143182,
    parameter int unsigned SETTLE_CYC = 36
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       est_in,
    input  logic [3:0] pair_code,
    output logic [3:0] code_q,
    output logic       dsteer
);
    localparam int unsigned TMAX = (GUARD_CYC > SETTLE_CYC) ? GUARD_CYC : SETTLE_CYC;
    localparam int unsigned TW   = $clog2(TMAX + 1);

    steer_state_t  state_q, state_d;
    logic [TW-1:0] timer_q, timer_d;
    logic          load;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            timer_q <= '0;
            code_q  <= 4'd0;
        end else begin
            state_q <= state_d;
            timer_q <= timer_d;
            if (load) code_q <= pair_code;
        end
    end

    always_comb begin
        state_d = state_q;
        timer_d = timer_q + TW'(1);
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                timer_d = '0;
                if (est_in) state_d = ST_QUALIFY;
            end
            ST_QUALIFY: begin
                if (!est_in) begin
                    state_d = ST_IDLE;
                    timer_d = '0;
                end else if (timer_q == TW'(GUARD_CYC - 1)) begin
                    state_d = ST_SETTLE;
                    timer_d = '0;
                    load    = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (!est_in) begin
                    state_d = ST_IDLE;
                    timer_d = '0;
                end else if (timer_q == TW'(SETTLE_CYC - 1)) begin
                    state_d = ST_HOLD;
                    timer_d = '0;
                end
            end
            ST_HOLD: begin
                timer_d = '0;
                if (!est_in) state_d = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (est_in) begin
                    state_d = ST_HOLD;
                    timer_d = '0;
                end else if (timer_q == TW'(GUARD_CYC - 1)) begin
                    state_d = ST_IDLE;
                    timer_d = '0;
                end
            end
            default: begin
                state_d = ST_IDLE;
                timer_d = '0;
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_HOLD, ST_RELEASE: dsteer = 1'b1;
            default:             dsteer = 1'b0;
        endcase
    end

endmodule

// File: rtl/dtmf_decoder.sv
module dtmf_decoder #(
    parameter int unsigned CLK_HZ     = 3579545,
    parameter int unsigned MIN_RUN    = 4,
    parameter int unsigned GUARD_CYC  = 143182,
    parameter int unsigned SETTLE_CYC = 36
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tone_low,
    input  logic       tone_high,
    input  logic       inhibit,
    input  logic       out_en,
    output logic       esteer,
    output logic       dsteer,
    output logic [3:0] key_out,
    output logic       key_drive
);
    logic       grp_ok  [2];
    logic [1:0] grp_sel [2];
    logic [1:0] hi_idx;
    logic [3:0] pair_code;
    logic [3:0] latched;
    logic       esteer_q;

    for (genvar g = 0; g < 2; g++) begin : g_band
        dtmf_tone_meter #(
            .CLK_HZ    (CLK_HZ),
            .HIGH_GROUP(g == 1),
            .MIN_RUN   (MIN_RUN)
        ) u_meter (
            .clk      (clk),
            .rst_n    (rst_n),
            .tone_in  ((g == 0) ? tone_low : tone_high),
            .block_top((g == 0) ? 1'b0 : inhibit),
            .tone_ok  (grp_ok[g]),
            .tone_sel (grp_sel[g])
        );
    end

    assign hi_idx = grp_sel[1];

    always_ff @(posedge clk) begin
        if (!rst_n) esteer_q <= 1'b0;
        else        esteer_q <= grp_ok[0] & grp_ok[1];
    end

    dtmf_key_map u_map (
        .row (grp_sel[0]),
        .col (grp_sel[1]),
        .code(pair_code)
    );

    dtmf_steer_fsm #(
        .GUARD_CYC (GUARD_CYC),
        .SETTLE_CYC(SETTLE_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .est_in   (esteer_q),
        .pair_code(pair_code),
        .code_q   (latched),
        .dsteer   (dsteer)
    );

    assign esteer    = esteer_q;
    assign key_out   = out_en ? latched : 4'd0;
    assign key_drive = out_en;

endmodule

// File: rtl/dtmf_decoder_chk.sv
module dtmf_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       esteer,
    input logic       dsteer,
    input logic       inhibit,
    input logic       out_en,
    input logic [3:0] key_out,
    input logic [1:0] hi_idx
);
    assert_release_after_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dsteer) |-> !$past(esteer));

    assert_code_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && $past(out_en) && key_out != $past(key_out)) |-> !dsteer);

    assert_no_top_column_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (esteer && $past(inhibit)) |-> ($past(hi_idx) != 2'd3));

    assert_no_instant_steer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(esteer) && !dsteer) |=> !dsteer);
endmodule

bind dtmf_decoder dtmf_decoder_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .esteer (esteer),
    .dsteer (dsteer),
    .inhibit(inhibit),
    .out_en (out_en),
    .key_out(key_out),
    .hi_idx (hi_idx)
);

// File: tb/tb_dtmf_decoder.sv
module tb_dtmf_decoder;
    localparam int unsigned CLK_HZ = 178977;
    localparam int unsigned GUARD  = 150;
    localparam int unsigned SETTLE = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tone_low = 1'b0, tone_high = 1'b0, inhibit = 1'b0, out_en = 1'b1;
    logic esteer, dsteer, key_drive;
    logic [3:0] key_out;

    int lo_per = 0, hi_per = 0;
    int total = 0, bad = 0;
    logic [3:0] held = 4'd0;

    always #4 clk = ~clk;

    dtmf_decoder #(.CLK_HZ(CLK_HZ), .MIN_RUN(4), .GUARD_CYC(GUARD), .SETTLE_CYC(SETTLE)) dut (
        .clk(clk), .rst_n(rst_n), .tone_low(tone_low), .tone_high(tone_high),
        .inhibit(inhibit), .out_en(out_en), .esteer(esteer), .dsteer(dsteer),
        .key_out(key_out), .key_drive(key_drive));

    initial forever begin
        if (lo_per == 0) begin tone_low = 1'b0; @(negedge clk); end
        else begin
            tone_low = 1'b1; repeat (lo_per / 2) @(negedge clk);
            tone_low = 1'b0; repeat (lo_per - lo_per / 2) @(negedge clk);
        end
    end

    initial forever begin
        if (hi_per == 0) begin tone_high = 1'b0; @(negedge clk); end
        else begin
            tone_high = 1'b1; repeat (hi_per / 2) @(negedge clk);
            tone_high = 1'b0; repeat (hi_per - hi_per / 2) @(negedge clk);
        end
    end

    function automatic int row_hz(input int r);
        case (r) 0: return 697; 1: return 770; 2: return 852; default: return 941; endcase
    endfunction
    function automatic int col_hz(input int c);
        case (c) 0: return 1209; 1: return 1336; 2: return 1477; default: return 1633; endcase
    endfunction
    function automatic logic [3:0] exp_code(input int r, input int c);
        case ({r[1:0], c[1:0]})
            4'h0: return 4'd1;  4'h1: return 4'd2;  4'h2: return 4'd3;  4'h3: return 4'd13;
            4'h4: return 4'd4;  4'h5: return 4'd5;  4'h6: return 4'd6;  4'h7: return 4'd14;
            4'h8: return 4'd7;  4'h9: return 4'd8;  4'hA: return 4'd9;  4'hB: return 4'd15;
            4'hC: return 4'd11; 4'hD: return 4'd10; 4'hE: return 4'd12; default: return 4'd0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Stop both tones and let the block return to idle.
    task automatic silence(input int cycles);
        lo_per = 0; hi_per = 0;
        repeat (cycles) @(negedge clk);
    endtask

    // Key that must register; checks steering timing and the bus.
    task automatic press_ok(input int r, input int c, input logic oe, input string tag);
        int n;
        out_en = oe;
        lo_per = int'(CLK_HZ) / row_hz(r);
        hi_per = int'(CLK_HZ) / col_hz(c);
        n = 0;
        while (!esteer && n < 4000) begin @(negedge clk); n++; end
        chk(esteer, {tag, " R2 esteer rise"}, esteer, 1);
        n = 0;
        while (!dsteer && n < 2000) begin @(negedge clk); n++; end
        chk(n == int'(GUARD + SETTLE + 1), {tag, " R5 dsteer latency"}, n, GUARD + SETTLE + 1);
        held = exp_code(r, c);
        chk(key_out == (oe ? held : 4'd0), {tag, " R6/R8 key bus"}, key_out, oe ? held : 0);
        chk(key_drive == oe, {tag, " R8 drive flag"}, key_drive, oe);
        lo_per = 0; hi_per = 0;
        n = 0;
        while (esteer && n < 1000) begin @(negedge clk); n++; end
        chk(!esteer && n < 700, {tag, " R4 esteer fall"}, n, 700);
        n = 0;
        while (dsteer && n < 2000) begin @(negedge clk); n++; end
        chk(n == int'(GUARD + 1), {tag, " R7 dsteer release"}, n, GUARD + 1);
        out_en = 1'b1;
        @(negedge clk);
        chk(key_out == held, {tag, " R10 code holds"}, key_out, held);
        silence(20);
    endtask

    // Stimulus that must never raise early steering; latch must keep held.
    task automatic expect_reject(input int lp, input int hp, input string req);
        bit seen;
        out_en = 1'b1;
        lo_per = lp; hi_per = hp;
        seen = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (esteer || dsteer) seen = 1'b1;
        end
        chk(!seen, {req, " no steering"}, seen, 0);
        chk(key_out == held, {req, " code kept"}, key_out, held);
        silence(600);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(!esteer, "R1 esteer", esteer, 0);
        chk(!dsteer, "R1 dsteer", dsteer, 0);
        chk(key_out == 4'd0, "R1 code", key_out, 0);
        rst_n = 1'b1;
        repeat (400) @(negedge clk);
        chk(!esteer && !dsteer, "R1 idle after reset", esteer, 0);

        // R6 all sixteen keys
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                press_ok(r, c, 1'b1, "R6 sweep");

        // R8 bus disabled during registration
        press_ok(1, 1, 1'b0, "R8 oe low");

        // R2 off-frequency low tone, R3 single tones
        expect_reject((int'(CLK_HZ) / 697) * 11 / 10, int'(CLK_HZ) / 1336, "R2 off tone");
        expect_reject(int'(CLK_HZ) / 852, 0, "R3 low only");
        expect_reject(0, int'(CLK_HZ) / 1477, "R3 high only");

        // R9 inhibit: letter key rejected, other columns still decode
        press_ok(1, 1, 1'b1, "R9 preload");
        inhibit = 1'b1;
        expect_reject(int'(CLK_HZ) / 697, int'(CLK_HZ) / 1633, "R9 inhibited A");
        expect_reject(int'(CLK_HZ) / 941, int'(CLK_HZ) / 1633, "R9 inhibited D");
        press_ok(2, 0, 1'b1, "R9 other column");
        inhibit = 1'b0;

        // Random keys with random enables
        for (int i = 0; i < 8; i++) begin
            int r, c;
            r = int'($urandom_range(3, 0));
            c = int'($urandom_range(3, 0));
            press_ok(r, c, logic'($urandom_range(1, 0)), "R8 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule